// File: doc/BRIEF.md
# Burst-Aware Round-Robin Port Arbiter

This block shares one memory controller port among several bus masters. Each master raises a request and tags it with a transfer kind: a single access, a burst of known length, or an incrementing burst whose length is unknown. The arbiter hands the port to one master at a time and rotates ownership fairly among the masters that are asking.

Ownership can change hands only at safe points, so that a burst is not split in a way that costs memory throughput. The port may move when no master holds it, when the holder's single access finishes, or when the holder's burst reaches its predicted end. For a burst of known length, that end is its final beat. For an incrementing burst, a predicted end falls after every group of four beats, so a long open-ended burst can still be pre-empted. The arbiter counts the holder's data beats to find these points. Command generation, refresh and data steering are left to the controller behind it.

Top module: `burst_rr_arbiter`

## Requirements
- R1: Grants rotate. After master k is granted, the next grant decision searches masters k+1, k+2, ... wrapping past the highest index, and gives the port to the first one that requests.
- R2: With the rotation pointer at master 0, as after reset, simultaneous requests are resolved to the lowest-numbered requester.
- R3: When no master holds the port, a request sampled on a clock edge is granted from that same edge on.
- R4: A transfer of type 2'b01 (single) is a permitted switch point on the cycle in which the holder's beat strobe is high.
- R5: A transfer of type 2'b10 (fixed burst) with length field L lasts L+1 beats. The switch point is the cycle with the (L+1)-th beat strobe of the holder, so L=15 gives 16 beats.
- R6: A transfer of type 2'b11 (incrementing burst) reaches a switch point on every fourth beat of its grant. If others request, it loses the port. If not, it is granted again and its count restarts.
- R7: Outside a switch point the grant stays unchanged, even if other masters request or the holder drops its request.
- R8: The beat count advances only on the holder's own beat strobe. Strobes from other masters are ignored, and the count restarts on every new grant.
- R9: At a switch point with no request pending, the grant vector goes to all zeros and the index to 0.
- R10: Synchronous active-high reset clears the grant and returns the rotation pointer to master 0.
- R11: The grant vector is one-hot or zero, and the index equals the position of its set bit (0 when idle). Both are registered and change only on the clock edge that ends a switch-point cycle.
- R12: A requesting master whose type is 2'b00 is handled exactly like a single access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Per-master request |
| xfer_type | input | 2*N_MASTERS | Per-master transfer type; master i at bits [2i+1:2i] |
| burst_len | input | LEN_W*N_MASTERS | Per-master fixed-burst length minus one; master i at bits [LEN_W*i+LEN_W-1:LEN_W*i] |
| beat | input | N_MASTERS | Per-master data-beat strobe |
| grant | output | N_MASTERS | One-hot grant, zero when idle |
| grant_idx | output | $clog2(N_MASTERS) | Index of the granted master, 0 when idle |

## Verification
Every result is due one clock after the stimulus that decides it. Grant and index come from the registers loaded on the edge that closes a switch-point cycle, so a request or final beat driven before edge n appears on the outputs just after edge n. The bench drives each vector a short time after a rising edge, waits for the next rising edge, and samples two nanoseconds later. Each expected grant therefore belongs to exactly one driven cycle. In the long fixed-burst and held-incrementing-burst cases, the grant is checked on every intermediate cycle, so a switch that comes one beat early or one beat late is caught.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;

   typedef enum logic [1:0] {
      XF_NONE   = 2'b00,
      XF_SINGLE = 2'b01,
      XF_FIXED  = 2'b10,
      XF_INCR   = 2'b11
   } xfer_e;

endpackage

// File: rtl/burst_rr_pick.sv
// Round-robin search: first requester at or after the pointer, wrapping.
module burst_rr_pick #(
   parameter int N_MASTERS = 4,
   localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [IDX_W-1:0]     ptr,
   output logic                 found,
   output logic [IDX_W-1:0]     pick,
   output logic [IDX_W-1:0]     pick_next
);

   localparam bit POW2 = ((1 << IDX_W) == N_MASTERS);

   always_comb begin
      int c;
      logic [IDX_W-1:0] cand;
      found = 1'b0;
      pick  = '0;
      for (int off = 0; off < N_MASTERS; off++) begin
         c = int'(ptr) + off;
         if (c >= N_MASTERS) c = c - N_MASTERS;
         cand = IDX_W'(c);
         if (!found && req[cand]) begin
            found = 1'b1;
            pick  = cand;
         end
      end
   end

   // wrap of the successor index: free overflow or explicit compare
   generate
      if (POW2) begin : g_wrap_free
         assign pick_next = pick + IDX_W'(1);
      end else begin : g_wrap_cmp
         assign pick_next = (pick == IDX_W'(N_MASTERS - 1)) ? '0 : pick + IDX_W'(1);
      end
   endgenerate

endmodule

// File: rtl/burst_beat_tracker.sv
// Holds the kind and length of the granted transfer and flags its switch point.
module burst_beat_tracker
   import burst_arb_pkg::*;
#(
   parameter int LEN_W    = 4,
   parameter int BOUNDARY = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  xfer_e            load_type,
   input  logic [LEN_W-1:0] load_len,
   input  logic             active,
   input  logic             beat,
   output logic             at_end
);

   localparam int BW    = (BOUNDARY > 1) ? $clog2(BOUNDARY) : 1;
   localparam int CNT_W = (LEN_W > BW) ? LEN_W : BW;

   xfer_e             kind_q;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q <= XF_SINGLE;
         len_q  <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         kind_q <= (load_type == XF_NONE) ? XF_SINGLE : load_type;
         len_q  <= load_len;
         cnt_q  <= '0;
      end else if (active && beat) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      unique case (kind_q)
         XF_FIXED: at_end = active && beat && (cnt_q == CNT_W'(len_q));
         XF_INCR:  at_end = active && beat && (cnt_q == CNT_W'(BOUNDARY - 1));
         default:  at_end = active && beat;
      endcase
   end

   // R5: a fixed burst never counts past its last beat
   a_r5_fixed_bound: assert property (@(posedge clk) disable iff (rst)
      (active && kind_q == XF_FIXED) |-> (cnt_q <= CNT_W'(len_q)));

   // R6: an incrementing burst never runs past its pre-emption boundary
   a_r6_incr_bound: assert property (@(posedge clk) disable iff (rst)
      (active && kind_q == XF_INCR) |-> (cnt_q < CNT_W'(BOUNDARY)));

   // R8: without a load, the count moves only on a holder beat
   a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !(active && beat)) |=> $stable(cnt_q));

endmodule

// File: rtl/burst_rr_arbiter.sv
module burst_rr_arbiter
   import burst_arb_pkg::*;
#(
   parameter int N_MASTERS     = 4,
   parameter int LEN_W         = 4,
   parameter int INCR_BOUNDARY = 4,
   localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [N_MASTERS-1:0]        req,
   input  logic [2*N_MASTERS-1:0]      xfer_type,
   input  logic [LEN_W*N_MASTERS-1:0]  burst_len,
   input  logic [N_MASTERS-1:0]        beat,
   output logic [N_MASTERS-1:0]        grant,
   output logic [IDX_W-1:0]            grant_idx
);

   // elaboration-time parameter checks
   generate
      if (N_MASTERS < 2) begin : g_bad_n
         $error("burst_rr_arbiter: N_MASTERS must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("burst_rr_arbiter: LEN_W must be at least 1");
      end
      if (INCR_BOUNDARY < 1 || (INCR_BOUNDARY & (INCR_BOUNDARY - 1)) != 0) begin : g_bad_bnd
         $error("burst_rr_arbiter: INCR_BOUNDARY must be a power of two");
      end
   endgenerate

   xfer_e            type_arr [N_MASTERS];
   logic [LEN_W-1:0] len_arr  [N_MASTERS];

   generate
      for (genvar i = 0; i < N_MASTERS; i++) begin : g_unpack
         assign type_arr[i] = xfer_e'(xfer_type[2*i +: 2]);
         assign len_arr[i]  = burst_len[LEN_W*i +: LEN_W];
      end
   endgenerate

   logic             owner_valid;
   logic [IDX_W-1:0] owner_idx;
   logic [IDX_W-1:0] ptr_q;
   logic             win_found;
   logic [IDX_W-1:0] win_idx;
   logic [IDX_W-1:0] win_next;
   logic             at_end;
   logic             may_switch;
   logic             owner_beat;

   burst_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
      .req       (req),
      .ptr       (ptr_q),
      .found     (win_found),
      .pick      (win_idx),
      .pick_next (win_next)
   );

   assign owner_beat = beat[owner_idx];

   burst_beat_tracker #(.LEN_W(LEN_W), .BOUNDARY(INCR_BOUNDARY)) u_track (
      .clk       (clk),
      .rst       (rst),
      .load      (may_switch),
      .load_type (type_arr[win_idx]),
      .load_len  (len_arr[win_idx]),
      .active    (owner_valid),
      .beat      (owner_beat),
      .at_end    (at_end)
   );

   assign may_switch = !owner_valid || at_end;

   always_ff @(posedge clk) begin
      if (rst) begin
         owner_valid <= 1'b0;
         owner_idx   <= '0;
         ptr_q       <= '0;
      end else if (may_switch) begin
         owner_valid <= win_found;
         owner_idx   <= win_found ? win_idx : '0;
         if (win_found) ptr_q <= win_next;
      end
   end

   generate
      for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
         assign grant[g] = owner_valid && (owner_idx == IDX_W'(g));
      end
   endgenerate

   assign grant_idx = owner_idx;

   // R11: at most one grant at a time
   a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   // R7: grant frozen away from switch points
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (owner_valid && !may_switch) |=> $stable(grant));

   // R3: an idle port with a request becomes owned on the next edge
   a_r3_idle_grant: assert property (@(posedge clk) disable iff (rst)
      (!owner_valid && (|req)) |=> owner_valid);

   // R9: switch point with nobody asking leaves the port idle
   a_r9_idle: assert property (@(posedge clk) disable iff (rst)
      (may_switch && !(|req)) |=> (grant == '0));

   // R1: a fresh grant always goes to a master that was requesting
   a_r1_requested: assert property (@(posedge clk) disable iff (rst)
      (may_switch && (|req)) |=> ((grant & $past(req)) != '0));

endmodule

// File: tb/burst_rr_arbiter_tb.sv
module burst_rr_arbiter_tb;

   localparam int N     = 4;
   localparam int LW    = 4;
   localparam int IW    = 2;

   logic            clk = 1'b0;
   logic            rst;
   logic [N-1:0]    req;
   logic [2*N-1:0]  xfer_type;
   logic [LW*N-1:0] burst_len;
   logic [N-1:0]    beat;
   logic [N-1:0]    grant;
   logic [IW-1:0]   grant_idx;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;   // 125 MHz

   burst_rr_arbiter #(.N_MASTERS(N), .LEN_W(LW), .INCR_BOUNDARY(4)) u_dut (
      .clk(clk), .rst(rst), .req(req), .xfer_type(xfer_type),
      .burst_len(burst_len), .beat(beat), .grant(grant), .grant_idx(grant_idx)
   );

   // table rows: {req, beat, expected grant}; types m0 incr, m1 fixed L=2,
   // m2 single, m3 fixed L=0
   localparam logic [11:0] TBL [0:20] = '{
      12'h000, 12'h701, 12'h711, 12'h701, 12'h711, 12'h711, 12'h712,
      12'h732, 12'h722, 12'h724, 12'hF04, 12'hF48, 12'hF81, 12'h001,
      12'h011, 12'h011, 12'h011, 12'h010, 12'h404, 12'h444, 12'h040
   };

   function automatic logic [IW-1:0] idx_of(input logic [N-1:0] g);
      logic [IW-1:0] r = '0;
      for (int i = 0; i < N; i++) if (g[i]) r = IW'(i);
      return r;
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic check(input string tag, input logic [N-1:0] exp_g);
      n_checks++;
      if (grant !== exp_g || grant_idx !== idx_of(exp_g)) begin
         n_fail++;
         $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
                  tag, grant, grant_idx, exp_g, idx_of(exp_g));
      end
   endtask

   // apply inputs after an edge, wait one edge, sample 2 ns later
   task automatic step(input logic [N-1:0] r, input logic [N-1:0] b,
                       input logic [N-1:0] exp_g, input string tag);
      req  = r;
      beat = b;
      @(posedge clk);
      #2;
      check(tag, exp_g);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         report();
      end
   end

   initial begin
      rst = 1'b1; req = '0; beat = '0;
      xfer_type = 8'h9B; burst_len = 16'h0020;
      @(posedge clk); @(posedge clk); #2;
      check("R10 reset state", 4'b0000);
      rst = 1'b0;

      // R1 R2 R3 R4 R5 R6 R7 R8 R9 via table
      for (int i = 0; i < 21; i++) begin
         step(TBL[i][11:8], TBL[i][7:4], TBL[i][3:0],
              $sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R7 R8 R9 R11)", i));
      end

      // R10: reset mid-grant clears it and restores pointer to master 0
      step(4'b0001, 4'b0000, 4'b0001, "R10 pre-reset grant m0");
      rst = 1'b1;
      step(4'b0001, 4'b0000, 4'b0000, "R10 reset clears grant");
      rst = 1'b0;
      step(4'b0011, 4'b0000, 4'b0001, "R10 R2 pointer back at m0");

      // R5: longest fixed burst, L=15 -> 16 beats
      rst = 1'b1; step(4'b0000, 4'b0000, 4'b0000, "R10 reset");
      rst = 1'b0;
      xfer_type = 8'h09; burst_len = 16'h00F0;
      step(4'b0010, 4'b0000, 4'b0010, "R5 grant m1 fixed 16");
      for (int k = 0; k < 15; k++)
         step(4'b0011, 4'b0010, 4'b0010, $sformatf("R5 held beat %0d", k + 1));
      step(4'b0011, 4'b0010, 4'b0001, "R5 R1 switch after 16th beat");

      // R12: type 00 behaves as single
      rst = 1'b1; step(4'b0000, 4'b0000, 4'b0000, "R10 reset");
      rst = 1'b0;
      xfer_type = 8'h00; burst_len = 16'h0000;
      step(4'b0100, 4'b0000, 4'b0100, "R12 grant m2 type 00");
      step(4'b0110, 4'b0000, 4'b0100, "R12 R7 held without beat");
      step(4'b0110, 4'b0100, 4'b0010, "R12 R1 switch after one beat");

      report();
   end

endmodule